// File: doc/BRIEF.md
# Saturating Two's-Complement Floating-Point Multiplier

This block multiplies two floating-point numbers held in a 48-bit format. Each number has a 24-bit mantissa and a 24-bit exponent word. The mantissa is a normalized two's-complement fraction with its binary point just after the sign bit and no hidden bit. The exponent is a 14-bit unsigned value biased by 8191 and held in the low bits of its word. A number's value is mant × 2^(exp − 8191). Zero has exactly one form: both fields are all zeros.

The block multiplies the mantissas, adds the exponents, removes one bias, renormalizes and rounds to nearest, and then checks the exponent range. It does not trap on a result that is out of range. It replaces the result with the closest representable value and sets a sticky error flag, which only an explicit clear input resets. Operands enter on a valid/ready handshake. The result sits in an output register that also has a valid/ready handshake, so the block adds one cycle of latency and can take one operation per cycle.

Top module: `fpmul_top`

## Requirements
- R1: For legal operands, the result mantissa is the normalized, rounded product. The result exponent is exp_a + exp_b − 8191 plus the normalization adjustment. For example, 0.75 × −0.75 with both exponents 0x1FFF gives mant 0xB80000 and exp 0x1FFF.
- R2: If the raw product's magnitude is below one half, the mantissa is shifted left by one bit and the exponent is reduced by one. For example, 0x400000 × 0x400000 with both exponents 0x1FFF gives 0x400000 with exp 0x1FFE.
- R3: The product −1.0 × −1.0 (0x800000 × 0x800000) is delivered as 0x400000 and the exponent is raised by one.
- R4: Rounding is to nearest, and a tie rounds toward plus infinity. A rounded value that leaves the normalized range is renormalized. For example, 0xBFFFFF × 0x7FFFFF rounds to −0.5 and is delivered as 0x800000 with the exponent reduced by one. Also, 0x600001 × 0x400001 rounds up to 0x600002 + 1.
- R5: Exponent arithmetic uses 16 bits, and bit 14 set (with bit 15 clear) means overflow. On overflow the result is 0x7FFFFF for a positive result or 0x800000 for a negative result, with exp 0x3FFF, and the error flag is set. An exponent of exactly 0x3FFF is not an overflow.
- R6: A negative exponent after adjustment (bit 15 set) is an underflow. The result is then zero and the error flag is set. An exponent of exactly 0 is not an underflow.
- R7: If either mantissa is zero, the result is zero (mant 0, exp 0) and the error flag is not set, whatever the exponents are.
- R8: The error flag is sticky and is cleared by err_clr. If err_clr and a new saturating result arrive in the same accept cycle, the flag stays set.
- R9: in_ready is high whenever out_valid is low or out_ready is high. While out_valid is high and out_ready is low, the result stays unchanged and no new operation is accepted.
- R10: Bits 23..14 of res_exp are always zero, and a valid result's mantissa is zero or normalized (its top two bits differ).
- R11: After reset, out_valid and err_flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The block can accept an operand pair |
| a_mant | input | 24 | Operand A mantissa |
| a_exp | input | 24 | Operand A exponent word |
| b_mant | input | 24 | Operand B mantissa |
| b_exp | input | 24 | Operand B exponent word |
| out_valid | output | 1 | res_mant and res_exp hold a result |
| out_ready | input | 1 | The consumer takes the result |
| res_mant | output | 24 | Result mantissa |
| res_exp | output | 24 | Result exponent word |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky saturation flag |

## Verification
The hardest path to reach is the rounding step that carries the mantissa out of its normalized range. Only narrow operand pairs cause it. The product must land within half an LSB above −0.5 for the negative case, and only −1.0 × −1.0 produces the positive +1.0 case. The bench drives 0xBFFFFF × 0x7FFFFF, whose expected result was worked out by hand to round exactly to −0.5. It also combines the +1.0 exponent increment with the largest exponents, so that the adjustment alone crosses into overflow.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int FPM_MW   = 24;   // mantissa width
  localparam int FPM_EW   = 14;   // used exponent bits
  localparam int FPM_EFW  = 24;   // exponent word width
  localparam int FPM_BIAS = (1 << (FPM_EW - 1)) - 1;
endpackage

// File: rtl/fpm_mant_core.sv
module fpm_mant_core #(
  parameter int MW = 24
) (
  input  logic [MW-1:0]     a_m,
  input  logic [MW-1:0]     b_m,
  output logic [MW-1:0]     m_o,
  output logic signed [2:0] adj_o
);
  localparam int PW = 2 * MW;

  function automatic logic [PW-1:0] sext(input logic [MW-1:0] v);
    return {{MW{v[MW-1]}}, v};
  endfunction

  // round half up, then keep the top MW+1 bits
  function automatic logic [MW:0] round_top(input logic [PW-1:0] v);
    logic [PW-1:0] t;
    t = v + {{(PW-MW+1){1'b0}}, 1'b1, {(MW-2){1'b0}}};
    return t[PW-1:MW-1];
  endfunction

  logic [PW-1:0] prod, q;
  logic          shift, pos_c, neg_u;
  logic [MW:0]   r;

  assign prod  = sext(a_m) * sext(b_m);
  assign shift = (prod[PW-2] == prod[PW-3]);
  assign q     = shift ? (prod << 1) : prod;
  assign r     = round_top(q);
  assign pos_c = ~r[MW] & r[MW-1];
  assign neg_u = r[MW] & (r[MW-1] == r[MW-2]);

  always_comb begin
    if (pos_c)      m_o = r[MW:1];
    else if (neg_u) m_o = {r[MW-2:0], 1'b0};
    else            m_o = r[MW-1:0];
    adj_o = 3'sd0;
    if (shift) adj_o = adj_o - 3'sd1;
    if (pos_c) adj_o = adj_o + 3'sd1;
    if (neg_u) adj_o = adj_o - 3'sd1;
  end
endmodule

// File: rtl/fpm_exp_core.sv
module fpm_exp_core #(
  parameter int EW   = 14,
  parameter int BIAS = 8191
) (
  input  logic [EW-1:0]     ea,
  input  logic [EW-1:0]     eb,
  input  logic signed [2:0] adj,
  output logic [EW-1:0]     e_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int ESW = EW + 2;
  localparam logic [ESW-1:0] BIAS_V = ESW'(BIAS);

  function automatic logic [ESW-1:0] exp_sum(input logic [EW-1:0] x, input logic [EW-1:0] y,
                                             input logic [2:0] d);
    return {2'b00, x} + {2'b00, y} - BIAS_V + {{(ESW-3){d[2]}}, d};
  endfunction

  logic [ESW-1:0] sum;
  assign sum   = exp_sum(ea, eb, adj);
  assign unf_o = sum[ESW-1];
  assign ovf_o = ~sum[ESW-1] & sum[EW];
  assign e_o   = sum[EW-1:0];
endmodule

// File: rtl/fpmul_top.sv
module fpmul_top
  import fpm_pkg::*;
#(
  parameter int MW   = FPM_MW,
  parameter int EW   = FPM_EW,
  parameter int EFW  = FPM_EFW,
  parameter int BIAS = FPM_BIAS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [MW-1:0]  a_mant,
  input  logic [EFW-1:0] a_exp,
  input  logic [MW-1:0]  b_mant,
  input  logic [EFW-1:0] b_exp,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [MW-1:0]  res_mant,
  output logic [EFW-1:0] res_exp,
  input  logic           err_clr,
  output logic           err_flag
);
  localparam logic [MW-1:0] M_POS_MAX = {1'b0, {(MW-1){1'b1}}};
  localparam logic [MW-1:0] M_NEG_MAX = {1'b1, {(MW-1){1'b0}}};
  localparam logic [EW-1:0] E_MAX     = {EW{1'b1}};

  logic [MW-1:0]     core_m;
  logic signed [2:0] core_adj;
  logic [EW-1:0]     core_e;
  logic              ovf_evt, unf_evt, zero_in, sat_evt, fire, neg_res;
  logic              exp_pad_nz;
  logic [MW-1:0]     nxt_m;
  logic [EW-1:0]     nxt_e;

  fpm_mant_core #(.MW(MW)) u_mant (
    .a_m(a_mant), .b_m(b_mant), .m_o(core_m), .adj_o(core_adj)
  );

  fpm_exp_core #(.EW(EW), .BIAS(BIAS)) u_exp (
    .ea(a_exp[EW-1:0]), .eb(b_exp[EW-1:0]), .adj(core_adj),
    .e_o(core_e), .ovf_o(ovf_evt), .unf_o(unf_evt)
  );

  assign exp_pad_nz = |{a_exp[EFW-1:EW], b_exp[EFW-1:EW]};
  assign zero_in    = (a_mant == '0) || (b_mant == '0);
  assign sat_evt    = ~zero_in & (ovf_evt | unf_evt);
  assign neg_res    = a_mant[MW-1] ^ b_mant[MW-1];
  assign in_ready   = ~out_valid | out_ready;
  assign fire       = in_valid & in_ready;

  always_comb begin
    if (zero_in || unf_evt) begin
      nxt_m = '0;
      nxt_e = '0;
    end else if (ovf_evt) begin
      nxt_m = neg_res ? M_NEG_MAX : M_POS_MAX;
      nxt_e = E_MAX;
    end else begin
      nxt_m = core_m;
      nxt_e = core_e;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_mant  <= '0;
      res_exp   <= '0;
      err_flag  <= 1'b0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        res_mant  <= nxt_m;
        res_exp   <= {{(EFW-EW){1'b0}}, nxt_e};
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (fire && sat_evt) err_flag <= 1'b1;
      else if (err_clr)    err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/fpm_chk.sv
module fpm_chk #(
  parameter int MW  = 24,
  parameter int EW  = 14,
  parameter int EFW = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [MW-1:0]  res_mant,
  input logic [EFW-1:0] res_exp,
  input logic           err_clr,
  input logic           err_flag,
  input logic           fire,
  input logic           zero_in,
  input logic           ovf_evt,
  input logic           unf_evt,
  input logic           exp_pad_nz
);
  AST_IN_EXP_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !exp_pad_nz);                                                      // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_mant) && $stable(res_exp)); // R9
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);                                          // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);                                              // R8
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !zero_in && (ovf_evt || unf_evt) |=> err_flag);                          // R8
  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && zero_in |=> res_mant == '0 && res_exp == '0);                            // R7
  AST_ZERO_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    fire && zero_in && !err_flag |=> !err_flag);                                     // R7
  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !zero_in && unf_evt |=> res_mant == '0 && res_exp == '0);                // R6
  AST_OVF_EXP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !zero_in && ovf_evt |=> res_exp == EFW'({EW{1'b1}}));                    // R5
  AST_RES_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> res_exp[EFW-1:EW] == '0 &&
                  (res_mant == '0 || res_mant[MW-1] != res_mant[MW-2]));             // R10
endmodule

bind fpmul_top fpm_chk #(.MW(MW), .EW(EW), .EFW(EFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .res_mant(res_mant),
  .res_exp(res_exp), .err_clr(err_clr), .err_flag(err_flag), .fire(fire),
  .zero_in(zero_in), .ovf_evt(ovf_evt), .unf_evt(unf_evt), .exp_pad_nz(exp_pad_nz)
);

// File: tb/tb_fpmul_top.sv
module tb_fpmul_top;
  logic        clk = 1'b0;
  logic        rst_n, in_valid, in_ready, out_valid, out_ready, err_clr, err_flag;
  logic [23:0] a_mant, a_exp, b_mant, b_exp, res_mant, res_exp;
  int n_chk = 0;
  int n_err = 0;

  localparam logic [23:0] E0 = 24'h001FFF;  // exponent for a scale of 1

  fpmul_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_mant(a_mant), .a_exp(a_exp), .b_mant(b_mant), .b_exp(b_exp),
    .out_valid(out_valid), .out_ready(out_ready), .res_mant(res_mant),
    .res_exp(res_exp), .err_clr(err_clr), .err_flag(err_flag)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [23:0] am, input logic [23:0] ae,
                        input logic [23:0] bm, input logic [23:0] be);
    @(negedge clk);
    a_mant = am; a_exp = ae; b_mant = bm; b_exp = be; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic op_chk(input string req, input logic [23:0] am, input logic [23:0] ae,
                        input logic [23:0] bm, input logic [23:0] be,
                        input logic [23:0] em, input logic [23:0] ee, input logic eerr);
    run_op(am, ae, bm, be);
    chk(req, {res_mant, res_exp}, {em, ee});
    chk(req, {47'd0, err_flag}, {47'd0, eerr});
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(posedge clk); #1; err_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; err_clr = 1'b0;
    a_mant = '0; a_exp = '0; b_mant = '0; b_exp = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset valid/err", {46'd0, out_valid, err_flag}, 48'd0);
    chk("R9 ready after reset", {47'd0, in_ready}, 48'd1);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_basic();
    op_chk("R1 0.75 x -0.75", 24'h600000, E0, 24'hA00000, E0, 24'hB80000, E0, 1'b0);
    op_chk("R2 0.5 x 0.5", 24'h400000, E0, 24'h400000, E0, 24'h400000, 24'h001FFE, 1'b0);
    op_chk("R2 0.75 x 0.5", 24'h600000, 24'h002000, 24'h400000, 24'h002000,
           24'h600000, 24'h002000, 1'b0);
    op_chk("R2 -1.0 x 0.5", 24'h800000, E0, 24'h400000, E0, 24'h800000, 24'h001FFE, 1'b0);
  endtask

  task automatic t_minus_one();
    op_chk("R3 -1 x -1", 24'h800000, E0, 24'h800000, E0, 24'h400000, 24'h002000, 1'b0);
  endtask

  task automatic t_round();
    op_chk("R4 round up", 24'h600001, E0, 24'h400001, E0, 24'h600003, 24'h001FFE, 1'b0);
    op_chk("R4 round down", 24'h400001, E0, 24'h400001, E0, 24'h400002, 24'h001FFE, 1'b0);
    op_chk("R4 round to -0.5", 24'hBFFFFF, E0, 24'h7FFFFF, E0, 24'h800000, 24'h001FFE, 1'b0);
  endtask

  task automatic t_edges();
    op_chk("R5 exp exactly max", 24'h600000, 24'h003FFF, 24'h800000, E0,
           24'hA00000, 24'h003FFF, 1'b0);
    op_chk("R6 exp exactly zero", 24'h600000, 24'h000000, 24'h800000, E0,
           24'hA00000, 24'h000000, 1'b0);
  endtask

  task automatic t_zero();
    op_chk("R7 zero A big exp", 24'h000000, 24'h000000, 24'h7FFFFF, 24'h003FFF,
           24'h0, 24'h0, 1'b0);
    op_chk("R7 zero B tiny exp", 24'h400000, 24'h000000, 24'h000000, 24'h000000,
           24'h0, 24'h0, 1'b0);
  endtask

  task automatic t_sat();
    op_chk("R5 overflow pos", 24'h400000, 24'h003FFF, 24'h400000, 24'h003FFF,
           24'h7FFFFF, 24'h003FFF, 1'b1);
    chk("R10 upper exp bits", {38'd0, res_exp[23:14]}, 48'd0);
    pulse_clr();
    op_chk("R5 overflow neg", 24'h800000, 24'h003FFF, 24'h400000, 24'h003FFF,
           24'h800000, 24'h003FFF, 1'b1);
    pulse_clr();
    op_chk("R5 overflow by -1x-1 increment", 24'h800000, 24'h003FFF, 24'h800000, E0,
           24'h7FFFFF, 24'h003FFF, 1'b1);
    pulse_clr();
    op_chk("R6 underflow", 24'h400000, 24'h000000, 24'h400000, 24'h000000,
           24'h0, 24'h0, 1'b1);
    pulse_clr();
    op_chk("R6 underflow by shift", 24'h400000, 24'h000000, 24'h400000, E0,
           24'h0, 24'h0, 1'b1);
  endtask

  task automatic t_sticky();
    pulse_clr();
    chk("R8 clear", {47'd0, err_flag}, 48'd0);
    run_op(24'h400000, 24'h003FFF, 24'h400000, 24'h003FFF);
    op_chk("R8 stays set on clean op", 24'h400000, E0, 24'h400000, E0,
           24'h400000, 24'h001FFE, 1'b1);
    @(negedge clk);
    a_mant = 24'h400000; a_exp = 24'h000000; b_mant = 24'h400000; b_exp = 24'h000000;
    in_valid = 1'b1; err_clr = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; err_clr = 1'b0;
    chk("R8 set wins over clear", {47'd0, err_flag}, 48'd1);
    pulse_clr();
    chk("R8 cleared again", {47'd0, err_flag}, 48'd0);
  endtask

  task automatic t_handshake();
    @(negedge clk); out_ready = 1'b0;
    run_op(24'h400000, E0, 24'h400000, E0);
    chk("R9 first result", {res_mant, res_exp}, {24'h400000, 24'h001FFE});
    @(negedge clk);
    a_mant = 24'h600000; a_exp = E0; b_mant = 24'hA00000; b_exp = E0; in_valid = 1'b1;
    #1;
    chk("R9 ready low on stall", {47'd0, in_ready}, 48'd0);
    @(posedge clk); #1;
    chk("R9 held under stall", {res_mant, res_exp}, {24'h400000, 24'h001FFE});
    chk("R9 valid held", {47'd0, out_valid}, 48'd1);
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk("R9 second result", {res_mant, res_exp}, {24'hB80000, E0});
    @(posedge clk); #1;
    chk("R9 valid drops", {47'd0, out_valid}, 48'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_minus_one();
    t_round();
    t_edges();
    t_zero();
    t_sat();
    t_sticky();
    t_handshake();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule